// File: doc/BRIEF.md
# Routed Interrupt Aggregation Controller

This block gathers interrupt events from eight on-chip sources into a sticky status register. Each bit of the status register is gated by a per-bit enable (mask) and then steered to one of two active-high interrupt lines, which feed the two external interrupt inputs of a small microcontroller. Software reads and clears the status register through a simple register port, with write-one-to-clear semantics.

Two of the eight source conditions are detected inside the block. The first is DMA completion, seen as a falling edge of a transfer-in-progress flag while a local DMA enable is set. The second is an unexpected drop of a storage-bus busy signal while a monitor enable is set. A separate request-active flag records that a new unmasked event has arrived. Any read of a dedicated acknowledge address clears this flag.

Top module: `irq_router`

## Requirements
- R1: Status bit map: bit 0 and bit 1 are I/O lines 0 and 1, bits 2 and 3 are timers 0 and 1, bit 4 is DMA, bits 5 and 6 are two-wire serial interfaces 0 and 1, and bit 7 is the bus core. An event sets its bit at the next clock edge, and the bit stays set until software clears it.
- R2: The mask register is at address 1. A mask bit of 0 keeps the matching status bit away from both lines. A mask bit of 1 lets it through.
- R3: The route register is at address 2. A route bit of 0 steers the matching bit to `irq_line0`, and a route bit of 1 steers it to `irq_line1`.
- R4: Each line is registered. Line k is the OR of (status AND mask AND route selects k), and it appears one clock after the status changes.
- R5: Control bit 0 at address 3 is the DMA enable. While it is set, a 1-to-0 transition of `dma_busy` sets status bit 4. While it is clear, that transition sets nothing.
- R6: Control bit 1 at address 3 is the busy monitor. While it is set, a 1-to-0 transition of `bus_bsy` with `bsy_release_ok` low sets status bit 7. If the monitor is off, or the release is expected, nothing is set.
- R7: Writing address 0 clears every status bit written as 1. If an event arrives in the same cycle, the event wins and its bit stays set.
- R8: The request-active flag is read at address 4, bit 0. It is set when an event arrives on a bit whose mask is 1. Any read of address 5 returns the flag and clears it, unless a new unmasked event arrives in the same cycle.
- R9: After reset, status, mask, route, control, the request flag and both lines are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_evt | input | 2 | Event pulses from I/O lines 0 and 1 |
| tmr_evt | input | 2 | Event pulses from timers 0 and 1 |
| twi_evt | input | 2 | Event pulses from two-wire serial interfaces 0 and 1 |
| dma_busy | input | 1 | DMA transfer-in-progress flag |
| bus_bsy | input | 1 | Storage-bus busy signal |
| bsy_release_ok | input | 1 | High when a drop of busy is expected |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq_line0 | output | 1 | Interrupt line to CPU input 0 |
| irq_line1 | output | 1 | Interrupt line to CPU input 1 |

## Verification
The status, mask and route registers can all be read back. A wrong status bit is therefore visible on the same read. The lines lag the status by exactly one clock, so a bad gating term or a wrong route shows at the port on the edge after the cause. A faulty edge detector either sets bit 4 or bit 7 when it must not, or misses the edge. Either way, the next read of address 0 shows it. A stale request flag shows at address 4 right after the acknowledge read.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    io_evt,
  input  logic [1:0]    tmr_evt,
  input  logic [1:0]    twi_evt,
  input  logic          dma_busy,
  input  logic          bus_bsy,
  input  logic          bsy_release_ok,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_line0,
  output logic          irq_line1
);
  localparam logic [AW-1:0] A_STAT = 0, A_MASK = 1, A_ROUTE = 2,
                            A_CTRL = 3, A_REQ = 4, A_ACK = 5;

  logic [DW-1:0] status, mask, route, evt;
  logic dma_ien, mon_en, req_active, dma_prev, bsy_prev;
  logic dma_fall, bsy_loss, new_req, ack_rd, clr_wr;

  assign dma_fall = dma_ien & dma_prev & ~dma_busy;
  assign bsy_loss = mon_en & bsy_prev & ~bus_bsy & ~bsy_release_ok;
  assign evt      = {bsy_loss, twi_evt, dma_fall, tmr_evt, io_evt};
  assign new_req  = |(evt & mask);
  assign ack_rd   = reg_rd && reg_addr == A_ACK;
  assign clr_wr   = reg_wr && reg_addr == A_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0; mask <= '0; route <= '0;
      dma_ien <= 1'b0; mon_en <= 1'b0; req_active <= 1'b0;
      dma_prev <= 1'b0; bsy_prev <= 1'b0;
      irq_line0 <= 1'b0; irq_line1 <= 1'b0;
    end else begin
      dma_prev <= dma_busy;
      bsy_prev <= bus_bsy;
      status   <= (clr_wr ? (status & ~reg_wdata) : status) | evt;
      if (reg_wr && reg_addr == A_MASK)  mask  <= reg_wdata;
      if (reg_wr && reg_addr == A_ROUTE) route <= reg_wdata;
      if (reg_wr && reg_addr == A_CTRL) begin
        dma_ien <= reg_wdata[0];
        mon_en  <= reg_wdata[1];
      end
      if (new_req)     req_active <= 1'b1;
      else if (ack_rd) req_active <= 1'b0;
      irq_line0 <= |(status & mask & ~route);
      irq_line1 <= |(status & mask & route);
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:       reg_rdata = status;
      A_MASK:       reg_rdata = mask;
      A_ROUTE:      reg_rdata = route;
      A_CTRL:       reg_rdata = {{(DW-2){1'b0}}, mon_en, dma_ien};
      A_REQ, A_ACK: reg_rdata = {{(DW-1){1'b0}}, req_active};
      default:      reg_rdata = '0;
    endcase
  end

  p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> (!irq_line0 && !irq_line1));
  p_dma_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(dma_ien));
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && evt == '0) |=> ((status & $past(reg_wdata)) == '0));
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !new_req) |=> !req_active);
  p_lines_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mask) == 1 && $stable(mask)) |=> !(irq_line0 && irq_line1));
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] io_evt = 0, tmr_evt = 0, twi_evt = 0;
  logic dma_busy = 0, bus_bsy = 0, bsy_release_ok = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_line0, irq_line1;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_router uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic lines(string req, logic e0, logic e1);
    @(negedge clk);
    check(req, {6'b0, irq_line1, irq_line0}, {6'b0, e1, e0});
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin rd(a[2:0], d); check("R9", d, 8'h00); end
    check("R9 lines", {6'b0, irq_line1, irq_line0}, 8'h00);
  endtask

  task automatic t_mask_route;
    logic [7:0] d;
    @(negedge clk); io_evt = 2'b01; @(negedge clk); io_evt = 0;
    rd(0, d); check("R1 hold", d, 8'h01);
    lines("R2 masked", 0, 0);
    wr(1, 8'hFF); lines("R4 line0", 1, 0);
    wr(2, 8'h01); lines("R3 route1", 0, 1);
    wr(1, 8'hFE); lines("R2 mask bit0", 0, 0);
    wr(1, 8'hFF);
    wr(0, 8'h01); rd(0, d); check("R7 w1c", d, 8'h00);
    lines("R4 cleared", 0, 0);
    wr(2, 8'h00);
  endtask

  task automatic t_evt_wins;
    logic [7:0] d;
    @(negedge clk); tmr_evt = 2'b01; @(negedge clk); tmr_evt = 0;
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 8'h04; tmr_evt = 2'b01;
    @(negedge clk); reg_wr = 0; tmr_evt = 0;
    rd(0, d); check("R7 event wins", d, 8'h04);
    wr(0, 8'hFF);
  endtask

  task automatic t_dma;
    logic [7:0] d;
    @(negedge clk); dma_busy = 1; @(negedge clk); dma_busy = 0;
    rd(0, d); check("R5 disabled", d, 8'h00);
    wr(3, 8'h01);
    @(negedge clk); dma_busy = 1; @(negedge clk); @(negedge clk); dma_busy = 0;
    rd(0, d); check("R5 fall", d, 8'h10);
    wr(0, 8'hFF); wr(3, 8'h00);
  endtask

  task automatic t_bsy;
    logic [7:0] d;
    @(negedge clk); bus_bsy = 1; @(negedge clk); bus_bsy = 0;
    rd(0, d); check("R6 monitor off", d, 8'h00);
    wr(3, 8'h02);
    @(negedge clk); bus_bsy = 1; bsy_release_ok = 1; @(negedge clk); bus_bsy = 0;
    @(negedge clk); bsy_release_ok = 0;
    rd(0, d); check("R6 expected", d, 8'h00);
    @(negedge clk); bus_bsy = 1; @(negedge clk); bus_bsy = 0;
    rd(0, d); check("R6 loss", d, 8'h80);
    wr(0, 8'hFF); wr(3, 8'h00);
  endtask

  task automatic t_req;
    logic [7:0] d;
    rd(4, d); rd(5, d); rd(4, d); check("R8 idle", d, 8'h00);
    wr(1, 8'hBF);
    @(negedge clk); twi_evt = 2'b10; @(negedge clk); twi_evt = 0;
    rd(4, d); check("R8 masked no req", d, 8'h00);
    wr(1, 8'hFF);
    @(negedge clk); twi_evt = 2'b10; @(negedge clk); twi_evt = 0;
    rd(4, d); check("R8 set", d, 8'h01);
    rd(5, d); check("R8 ack data", d, 8'h01);
    rd(4, d); check("R8 cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_mask_route(); t_evt_wins(); t_dma(); t_bsy(); t_req();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule